// File: doc/BRIEF.md
# Five-Channel Output Compare Unit

This block watches a shared 16-bit free-running count and raises a per-channel flag when the count reaches a value that software has placed in one of five compare registers. The count itself comes from outside, together with a one-cycle strobe that marks each cycle in which the count has just moved to a new value. Matches are judged only on that strobe, so a count that is held for several clocks by a prescaler can set a flag at most once per count value.

Software talks to the unit over a byte-wide register bus. Each compare value is 16 bits and occupies two consecutive byte addresses, high byte first. An enable byte selects which channels may raise flags. A flag byte records matches and is cleared by writing ones. The interrupt request is high while any channel has both its flag and its enable bit set. Channel 1 owns bit 7 of both bytes, and each following channel takes the next lower bit, down to bit 3 for channel 5.

Each channel holds a small state machine that makes a 16-bit update atomic. In state CH_ARMED the channel compares against its committed value. A high-byte write moves it to CH_STAGED (transition STAGE_HI), where the new high byte waits in a holding register while the old committed value stays in force. The next low-byte write commits both bytes and returns to CH_ARMED (transition COMMIT). A further high-byte write in CH_STAGED replaces the held byte (transition RESTAGE). A low-byte write in CH_ARMED commits at once with the current high byte (transition LO_ONLY).

Top module: `outcmp_unit`

## Requirements
- R1: After reset every compare register reads 0xFFFF, the enable byte and the flag byte read 0x00, and irq is 0.
- R2: Channel n (1 to 5) has its high byte at address 2(n-1) and its low byte at address 2(n-1)+1; the enable byte is at address 10 and the flag byte at address 11; reads return the committed compare value.
- R3: A high-byte write is held back: neither readback nor comparison sees it until a low-byte write to the same channel commits both bytes; a low-byte write with no held high byte keeps the committed high byte.
- R4: On a cycle with count_adv at 1 and count equal to channel n's committed value, flag bit 8-n (bit 7 for channel 1, bit 3 for channel 5) is set in the next cycle if enable bit 8-n is 1.
- R5: A channel whose enable bit is 0 never sets its flag; with the enable byte at 0x00 no flag is ever set.
- R6: With count_adv at 0 no flag is set, whatever the count.
- R7: Writing the flag byte clears exactly the bits written as 1 and leaves the others.
- R8: When a flag-byte write clearing bit b falls in the same cycle as a match that sets bit b, the bit ends up set.
- R9: irq is 1 exactly when some bit is 1 in both the flag byte and the enable byte; clearing the enable bit drops irq and leaves the flag as it was.
- R10: Bits 2 to 0 of the enable and flag bytes always read 0, and reads or writes at addresses 12 to 15 return 0 and change nothing.
- R11: After a commit, the next strobe with count equal to the new value sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count | input | 16 | Shared free-running count |
| count_adv | input | 1 | High for one cycle when count has taken a new value |
| bus_wr | input | 1 | Byte write strobe |
| bus_addr | input | 4 | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that can land in one cycle are a software write that clears flags and a compare match that sets one of the same flags. The bench provokes this by driving a flag-byte write of 0xFF in the very cycle that the strobe carries a count equal to one channel's value, with other flags already set. It then reads the flag byte and expects only the matching channel's bit to survive, showing that the set takes priority over the clear while the other written ones still clear.

// File: rtl/outcmp_pkg.sv
package outcmp_pkg;

    // Per-channel update state: compare with the committed value, or hold a
    // freshly written high byte until its low byte arrives.
    typedef enum logic [0:0] {
        CH_ARMED  = 1'b0,
        CH_STAGED = 1'b1
    } ch_state_e;

endpackage

// File: rtl/outcmp_channel.sv
module outcmp_channel
    import outcmp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_hi,
    input  logic                  wr_lo,
    input  logic [BYTE_W-1:0]     wdata,
    input  logic [2*BYTE_W-1:0]   count,
    input  logic                  count_adv,
    output logic [2*BYTE_W-1:0]   value,
    output logic                  hit
);

    localparam int CNT_W = 2 * BYTE_W;

    ch_state_e            state_q;
    ch_state_e            state_d;
    logic [BYTE_W-1:0]    stage_q;
    logic [BYTE_W-1:0]    stage_d;
    logic [CNT_W-1:0]     value_q;
    logic [CNT_W-1:0]     value_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: STAGE_HI, RESTAGE, COMMIT, LO_ONLY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_ARMED: begin
                if (wr_hi) begin
                    state_d = CH_STAGED;      // STAGE_HI
                end
            end
            CH_STAGED: begin
                if (wr_lo) begin
                    state_d = CH_ARMED;       // COMMIT
                end
            end
            default: state_d = CH_ARMED;
        endcase
    end

    // Data path driven by the state
    always_comb begin
        stage_d = stage_q;
        value_d = value_q;
        if (wr_hi) begin
            stage_d = wdata;                  // STAGE_HI or RESTAGE
        end
        if (wr_lo) begin
            if (state_q == CH_STAGED) begin
                value_d = {stage_q, wdata};   // COMMIT
            end else begin
                value_d = {value_q[CNT_W-1:BYTE_W], wdata}; // LO_ONLY
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '1;
            value_q <= '1;
        end else begin
            stage_q <= stage_d;
            value_q <= value_d;
        end
    end

    assign value = value_q;
    assign hit   = count_adv && (count == value_q);

endmodule

// File: rtl/outcmp_flags.sv
module outcmp_flags #(
    parameter int NUM_CH = 5,
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_mask,
    input  logic                  wr_flag,
    input  logic [BYTE_W-1:0]     wdata,
    input  logic [NUM_CH-1:0]     hit,
    output logic [BYTE_W-1:0]     mask,
    output logic [BYTE_W-1:0]     flag
);

    logic [BYTE_W-1:0] used_bits;
    logic [BYTE_W-1:0] hit_bits;
    logic [BYTE_W-1:0] clr_bits;
    logic [BYTE_W-1:0] mask_q;
    logic [BYTE_W-1:0] flag_q;

    // Channel 0 sits on the top bit, later channels walk downward.
    always_comb begin
        used_bits = '0;
        hit_bits  = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            used_bits[BYTE_W-1-i] = 1'b1;
            hit_bits[BYTE_W-1-i]  = hit[i];
        end
    end

    assign clr_bits = wr_flag ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            flag_q <= '0;
        end else begin
            if (wr_mask) begin
                mask_q <= wdata & used_bits;
            end
            // A match in the same cycle as a clear wins.
            flag_q <= (flag_q & ~clr_bits) | (hit_bits & mask_q);
        end
    end

    assign mask = mask_q;
    assign flag = flag_q;

endmodule

// File: rtl/outcmp_unit.sv
module outcmp_unit #(
    parameter int NUM_CH = 5,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*BYTE_W-1:0]   count,
    input  logic                  count_adv,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [BYTE_W-1:0]     bus_wdata,
    output logic [BYTE_W-1:0]     bus_rdata,
    output logic                  irq
);

    localparam int CNT_W     = 2 * BYTE_W;
    localparam int MASK_ADDR = 2 * NUM_CH;
    localparam int FLAG_ADDR = 2 * NUM_CH + 1;

    logic [NUM_CH-1:0] wr_hi;
    logic [NUM_CH-1:0] wr_lo;
    logic [NUM_CH-1:0] hit;
    logic [CNT_W-1:0]  values [NUM_CH];
    logic [BYTE_W-1:0] mask_q;
    logic [BYTE_W-1:0] flag_q;
    logic              wr_mask;
    logic              wr_flag;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign wr_hi[g] = bus_wr && (bus_addr == ADDR_W'(2 * g));
        assign wr_lo[g] = bus_wr && (bus_addr == ADDR_W'(2 * g + 1));

        outcmp_channel #(
            .BYTE_W (BYTE_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hi     (wr_hi[g]),
            .wr_lo     (wr_lo[g]),
            .wdata     (bus_wdata),
            .count     (count),
            .count_adv (count_adv),
            .value     (values[g]),
            .hit       (hit[g])
        );
    end

    assign wr_mask = bus_wr && (bus_addr == ADDR_W'(MASK_ADDR));
    assign wr_flag = bus_wr && (bus_addr == ADDR_W'(FLAG_ADDR));

    outcmp_flags #(
        .NUM_CH (NUM_CH),
        .BYTE_W (BYTE_W)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_mask),
        .wr_flag (wr_flag),
        .wdata   (bus_wdata),
        .hit     (hit),
        .mask    (mask_q),
        .flag    (flag_q)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(2 * i)) begin
                bus_rdata = values[i][CNT_W-1:BYTE_W];
            end
            if (bus_addr == ADDR_W'(2 * i + 1)) begin
                bus_rdata = values[i][BYTE_W-1:0];
            end
        end
        if (bus_addr == ADDR_W'(MASK_ADDR)) begin
            bus_rdata = mask_q;
        end
        if (bus_addr == ADDR_W'(FLAG_ADDR)) begin
            bus_rdata = flag_q;
        end
    end

    assign irq = |(flag_q & mask_q);

endmodule

// File: rtl/outcmp_unit_chk.sv
module outcmp_unit_chk #(
    parameter int NUM_CH = 5,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                count_adv,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [BYTE_W-1:0]   bus_wdata,
    input logic                irq,
    input logic [BYTE_W-1:0]   mask_q,
    input logic [BYTE_W-1:0]   flag_q
);

    localparam int FLAG_ADDR = 2 * NUM_CH + 1;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R4 / R5: a flag only rises after a strobe with its enable bit set
        p_flag_needs_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[BYTE_W-1-g]) |-> ($past(mask_q[BYTE_W-1-g]) && $past(count_adv)));
    end

    p_quiet_when_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> ((flag_q & ~$past(flag_q)) == '0));

    p_no_strobe_no_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !count_adv |=> ((flag_q & ~$past(flag_q)) == '0));

    p_clear_only_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_W'(FLAG_ADDR)) && !count_adv)
            |=> (flag_q == ($past(flag_q) & ~$past(bus_wdata))));

    p_irq_has_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_q != '0) && (mask_q != '0));

endmodule

bind outcmp_unit outcmp_unit_chk #(
    .NUM_CH (NUM_CH),
    .BYTE_W (BYTE_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_adv (count_adv),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .mask_q    (mask_q),
    .flag_q    (flag_q)
);

// File: tb/outcmp_unit_bench.sv
`timescale 1ns/1ps
module outcmp_unit_bench;

    localparam logic [3:0] A_MASK = 4'd10;
    localparam logic [3:0] A_FLAG = 4'd11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] count = 16'h0000;
    logic        count_adv = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    outcmp_unit u_outcmp_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (count),
        .count_adv (count_adv),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [15:0] ch_val(int ch);
        return 16'h1100 + 16'(ch) * 16'h0213;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_chk(string req, logic [3:0] a, logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, 16'(d), 16'(exp));
    endtask

    task automatic strobe(logic [15:0] c);
        @(negedge clk);
        count = c; count_adv = 1'b1;
        @(negedge clk);
        count_adv = 1'b0;
    endtask

    task automatic set_ch(int ch, logic [15:0] v);
        wr(4'(2 * ch), v[15:8]);
        wr(4'(2 * ch + 1), v[7:0]);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 10; a++) rd_chk("R1 compare reset", 4'(a), 8'hFF);
        rd_chk("R1 mask reset", A_MASK, 8'h00);
        rd_chk("R1 flag reset", A_FLAG, 8'h00);
        chk("R1 irq reset", 16'(irq), 16'h0);
    endtask

    task automatic t_stage;
        wr(4'd4, 8'h12);
        rd_chk("R3 staged high hidden", 4'd4, 8'hFF);
        wr(4'd5, 8'h34);
        rd_chk("R2 ch3 high readback", 4'd4, 8'h12);
        rd_chk("R2 ch3 low readback", 4'd5, 8'h34);
        wr(4'd3, 8'h77);
        rd_chk("R3 low-only keeps high", 4'd2, 8'hFF);
        rd_chk("R3 low-only new low", 4'd3, 8'h77);
        wr(A_MASK, 8'h80);
        wr(4'd0, 8'h20);
        strobe(16'h20FF);
        rd_chk("R3 staged byte not compared", A_FLAG, 8'h00);
        strobe(16'hFFFF);
        rd_chk("R3 old value still compared", A_FLAG, 8'h80);
        wr(A_FLAG, 8'h80);
        wr(4'd1, 8'h05);
        rd_chk("R3 commit high", 4'd0, 8'h20);
        strobe(16'h2005);
        rd_chk("R11 re-armed on new value", A_FLAG, 8'h80);
        wr(A_FLAG, 8'hFF);
    endtask

    task automatic t_each;
        logic [7:0] exp;
        for (int i = 0; i < 5; i++) set_ch(i, ch_val(i));
        wr(A_MASK, 8'hF8);
        exp = 8'h00;
        for (int i = 0; i < 5; i++) begin
            strobe(ch_val(i));
            exp[7 - i] = 1'b1;
            rd_chk("R4 channel bit position", A_FLAG, exp);
        end
        chk("R9 irq with flags", 16'(irq), 16'h1);
        wr(A_FLAG, 8'hFF);
        chk("R9 irq low after clear", 16'(irq), 16'h0);
    endtask

    task automatic t_disabled;
        wr(A_MASK, 8'h00);
        for (int i = 0; i < 5; i++) strobe(ch_val(i));
        rd_chk("R5 all disabled no flag", A_FLAG, 8'h00);
        chk("R5 irq quiet", 16'(irq), 16'h0);
        wr(A_MASK, 8'h50);
        for (int i = 0; i < 5; i++) strobe(ch_val(i));
        rd_chk("R5 only enabled channels", A_FLAG, 8'h50);
    endtask

    task automatic t_no_strobe;
        @(negedge clk);
        count = ch_val(0); count_adv = 1'b0;
        wr(A_MASK, 8'hD0);
        repeat (4) @(negedge clk);
        rd_chk("R6 equal count without strobe", A_FLAG, 8'h50);
    endtask

    task automatic t_w1c;
        wr(A_FLAG, 8'h10);
        rd_chk("R7 clear only ones", A_FLAG, 8'h40);
        wr(A_FLAG, 8'h00);
        rd_chk("R7 zero write keeps", A_FLAG, 8'h40);
    endtask

    task automatic t_irq_mask;
        wr(A_MASK, 8'h50);
        chk("R9 irq flag and mask", 16'(irq), 16'h1);
        wr(A_MASK, 8'h00);
        chk("R9 irq dropped by mask", 16'(irq), 16'h0);
        rd_chk("R9 flag kept under mask", A_FLAG, 8'h40);
    endtask

    task automatic t_set_wins;
        wr(A_MASK, 8'hF8);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_FLAG; bus_wdata = 8'hFF;
        count = ch_val(2); count_adv = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; count_adv = 1'b0;
        rd_chk("R8 set beats clear", A_FLAG, 8'h20);
        wr(A_FLAG, 8'hFF);
    endtask

    task automatic t_unused;
        wr(A_MASK, 8'hFF);
        rd_chk("R10 mask low bits zero", A_MASK, 8'hF8);
        for (int i = 0; i < 5; i++) strobe(ch_val(i));
        rd_chk("R10 flag low bits zero", A_FLAG, 8'hF8);
        wr(A_FLAG, 8'hFF);
        for (int a = 12; a < 16; a++) wr(4'(a), 8'hA5);
        rd_chk("R10 unused read zero", 4'd12, 8'h00);
        rd_chk("R10 unused write ignored mask", A_MASK, 8'hF8);
        rd_chk("R10 unused write ignored ch5", 4'd8, ch_val(4) >> 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stage();
        t_each();
        t_disabled();
        t_no_strobe();
        t_w1c();
        t_irq_mask();
        t_set_wins();
        t_unused();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule